// File: doc/BRIEF.md
# Full-Duplex Asynchronous Serial Transceiver with Address Filtering

The block sends and receives asynchronous serial frames. An external rate generator supplies `tick`, a one-cycle pulse that recurs OVS times per bit period (16 by default). Software selects the frame format through static configuration inputs:

- 8 or 9 data bits.
- An optional parity bit, even or odd.
- One or two stop bits.

Each direction has a holding register in front of its shift register. This lets software queue the next transmit word or leave a received word unread while a frame is still on the line. Four one-cycle interrupt pulses are produced:

- The transmit holding register has emptied.
- The final stop bit has been sent.
- A received word is ready.
- A received frame had an error.

An address-filter mode passes only frames whose ninth bit is 1. This lets a node ignore data that is meant for other nodes until software clears the filter. A loop-back mode feeds the transmitter's output straight into the receiver for self-test.

Top module: `uart_mp_xcvr`

## Requirements
- R1: After reset the block is in this state: `txd`=1, `tx_ready`=1, `rx_full`=0, `err_code`=0 and every interrupt output low.
- R2: A transmitted frame has this shape:
  - A low start bit comes first.
  - The 8 data bits follow, least significant first.
  - Stop bits at 1 end the frame.
  - Each bit lasts OVS ticks.
- R3: The ninth bit position is present on the line when `cfg_nine` or `cfg_par_en` is 1, directly after data bit 7. Its value is the parity bit when parity is on, and `tx_data[8]` otherwise. It is absent when both are 0.
- R4: The parity bit is set so the frame has the selected parity:
  - Even parity: the parity bit is the XOR of the 8 data bits.
  - Odd parity (`cfg_par_odd`=1): the parity bit is that XOR inverted.
  - A received mismatch sets `err_code[1]`.
- R5: `cfg_two_stop` selects two stop bits instead of one. `irq_tx_last` pulses for one cycle when the last stop bit period ends, so the frame lasts (10 + ninth + extra stop) × OVS ticks.
- R6: The transmit side is double-buffered:
  - `tx_ready` is 0 while the holding register is occupied.
  - A `tx_wr` while `tx_ready`=0 is ignored.
  - `irq_tx_empty` pulses in the same cycle that `txd` first drives the start bit of the word just taken from the holding register.
- R7: A received frame behaves as follows:
  - It loads `rx_data` = {ninth bit, data}, with `rx_data[8]`=0 when there is no ninth bit or parity is on.
  - It sets `rx_full` and pulses `irq_rx_full`.
  - `rx_rd` clears `rx_full`.
- R8: A stop bit sampled low sets `err_code[0]`, which is the framing error. The word is still delivered.
- R9: A frame that completes while `rx_full`=1 and `rx_rd`=0 sets `err_code[2]`, which is the overrun error. The unread word stays in `rx_data`, and `irq_rx_full` does not pulse.
- R10: `err_code` is rewritten for every accepted frame. `irq_err` pulses whenever any of its bits is set.
- R11: The receiver takes the majority of three samples at ticks OVS/2−1, OVS/2 and OVS/2+1 of each bit. A falling edge whose start bit reads high at mid-bit is discarded.
- R12: With `cfg_mp`=1, received frames whose ninth bit is 0 are dropped without any flag or interrupt. Frames whose ninth bit is 1 are delivered.
- R13: With `cfg_loop`=1 the receiver listens to `txd`, the `rxd` pin is ignored, and `txd` still drives the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling pulse, OVS per bit |
| cfg_nine | input | 1 | Ninth bit carries `tx_data[8]` |
| cfg_par_en | input | 1 | Parity bit enabled |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_mp | input | 1 | Drop frames whose ninth bit is 0 |
| cfg_loop | input | 1 | Internal loop from transmitter to receiver |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 9 | Transmit word |
| tx_ready | output | 1 | Transmit holding register free |
| rx_rd | input | 1 | Read strobe, clears `rx_full` |
| rx_data | output | 9 | Received word |
| rx_full | output | 1 | Unread received word present |
| err_code | output | 3 | {overrun, parity, framing} of last accepted frame |
| rxd | input | 1 | Serial input pin |
| txd | output | 1 | Serial output pin |
| irq_tx_empty | output | 1 | Holding register moved to shifter |
| irq_tx_last | output | 1 | Last stop bit finished |
| irq_rx_full | output | 1 | New word in `rx_data` |
| irq_err | output | 1 | Accepted frame had an error |

## Verification
Result timing on the transmit side:
- A write reaches the holding register one cycle after the strobe. The shifter loads one cycle later, which is when `txd` falls and `irq_tx_empty` rises, so the bench checks both at the same sample.
- The bench samples `txd` in the middle of every 64-cycle bit.
- Because tick phase is free-running, `irq_tx_last` is due within a 4-cycle window ending exactly nb × 64 cycles after the start edge, and the bench checks that window.

Result timing on the receive side:
- Receive results appear a few cycles after the middle of the last stop bit, behind the two-stage synchronizer and the mid-bit vote.
- The bench therefore reads `rx_data` and `err_code` only after `rx_full` rises or after the whole driven frame plus an idle bit.
- Interrupt pulses are tallied on every falling clock edge, so one-cycle pulses are counted exactly.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;
  localparam int unsigned FRAME_W = 12;  // start + 8 data + ninth + 2 stop

  typedef struct packed {
    logic nine;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } fmt_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_mp_tx.sv
module uart_mp_tx
  import uart_mp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  fmt_t       fmt,
  input  logic       wr,
  input  logic [8:0] wdata,
  output logic       ready,
  output logic       txd,
  output logic       irq_empty,
  output logic       irq_last
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] TLAST = CW'(OVS - 1);

  logic               hold_v;
  logic [8:0]         hold_d;
  logic               busy;
  logic [FRAME_W-1:0] sh;
  logic [CW-1:0]      tcnt;
  logic [3:0]         bcnt, blast;

  logic               load, has9, ninth;
  logic [FRAME_W-1:0] frame;
  logic [3:0]         nbits;

  always_comb begin
    load  = !busy && hold_v;
    has9  = fmt.nine | fmt.par_en;
    ninth = fmt.par_en ? ((^hold_d[7:0]) ^ fmt.par_odd) : hold_d[8];
    frame = has9 ? {2'b11, ninth, hold_d[7:0], 1'b0}
                 : {3'b111, hold_d[7:0], 1'b0};
    nbits = 4'd10 + {3'b000, has9} + {3'b000, fmt.two_stop};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v    <= 1'b0;
      hold_d    <= '0;
      busy      <= 1'b0;
      sh        <= '1;
      tcnt      <= '0;
      bcnt      <= '0;
      blast     <= '0;
      irq_empty <= 1'b0;
      irq_last  <= 1'b0;
    end else begin
      irq_empty <= load;
      irq_last  <= 1'b0;
      if (load) begin
        hold_v <= 1'b0;
      end else if (wr && !hold_v) begin
        hold_v <= 1'b1;
        hold_d <= wdata;
      end
      if (load) begin
        busy  <= 1'b1;
        sh    <= frame;
        tcnt  <= '0;
        bcnt  <= '0;
        blast <= nbits - 4'd1;
      end else if (busy && tick) begin
        if (tcnt == TLAST) begin
          tcnt <= '0;
          sh   <= {1'b1, sh[FRAME_W-1:1]};
          if (bcnt == blast) begin
            busy     <= 1'b0;
            irq_last <= 1'b1;
          end else begin
            bcnt <= bcnt + 4'd1;
          end
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  assign ready = !hold_v;
  assign txd   = sh[0];

  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> !txd) else $error("start bit not driven low");
  p_empty_at_start_r6: assert property (@(posedge clk) disable iff (rst)
    irq_empty |-> (busy && !txd)) else $error("empty pulse without start bit");
  p_full_write_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (wr && hold_v) |=> $stable(hold_d)) else $error("write into occupied holding register");
  p_last_idle_r5: assert property (@(posedge clk) disable iff (rst)
    irq_last |-> (!busy && txd)) else $error("last-bit pulse while line active");
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
  import uart_mp_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  fmt_t       fmt,
  input  logic       mp_en,
  input  logic       rx_in,
  input  logic       rd,
  output logic [8:0] rx_data,
  output logic       rx_full,
  output logic [2:0] err_code,
  output logic       irq_full,
  output logic       irq_err
);
  localparam int CW = $clog2(OVS);
  localparam int MID = OVS / 2;
  localparam logic [CW-1:0] TLAST = CW'(OVS - 1);
  localparam logic [CW-1:0] V_LO  = CW'(MID - 1);
  localparam logic [CW-1:0] V_MID = CW'(MID);
  localparam logic [CW-1:0] V_HI  = CW'(MID + 1);

  // synchronizer chain, one flop per stage
  logic [SYNC-1:0] sy;
  for (genvar g = 0; g < SYNC; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sy[g] <= 1'b1;
      else     sy[g] <= (g == 0) ? rx_in : sy[(g == 0) ? 0 : g - 1];
    end
  end

  logic       s, s_prev;
  rx_state_e  st;
  logic [CW-1:0] scnt;
  logic [3:0] bidx, last_idx;
  logic [8:0] sh;
  logic       v_lo, v_mid, second, ferr;
  logic       vote, at_mid, at_end, has9, n9, perr, fe, accept, free;
  logic [7:0] dbyte;

  always_comb begin
    s        = sy[SYNC-1];
    vote     = (v_lo & v_mid) | (v_lo & s) | (v_mid & s);
    at_mid   = tick && (scnt == V_HI);
    at_end   = tick && (scnt == TLAST);
    has9     = fmt.nine | fmt.par_en;
    last_idx = has9 ? 4'd8 : 4'd7;
    dbyte    = has9 ? sh[7:0] : sh[8:1];
    n9       = has9 & sh[8];
    perr     = fmt.par_en & (n9 ^ (^dbyte) ^ fmt.par_odd);
    fe       = ferr | !vote;
    accept   = !mp_en | n9;
    free     = !rx_full | rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_prev   <= 1'b1;
      st       <= RX_IDLE;
      scnt     <= '0;
      bidx     <= '0;
      sh       <= '0;
      v_lo     <= 1'b1;
      v_mid    <= 1'b1;
      second   <= 1'b0;
      ferr     <= 1'b0;
      rx_data  <= '0;
      rx_full  <= 1'b0;
      err_code <= '0;
      irq_full <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      s_prev   <= s;
      irq_full <= 1'b0;
      irq_err  <= 1'b0;
      if (rd) rx_full <= 1'b0;
      if (st != RX_IDLE && tick) begin
        scnt <= (scnt == TLAST) ? '0 : scnt + 1'b1;
        if (scnt == V_LO)  v_lo  <= s;
        if (scnt == V_MID) v_mid <= s;
      end
      unique case (st)
        RX_IDLE: begin
          if (s_prev && !s) begin
            st   <= RX_START;
            scnt <= '0;
          end
        end
        RX_START: begin
          if (at_mid && vote) begin
            st <= RX_IDLE;
          end else if (at_end) begin
            st   <= RX_DATA;
            bidx <= '0;
          end
        end
        RX_DATA: begin
          if (at_mid) sh <= {vote, sh[8:1]};
          if (at_end) begin
            if (bidx == last_idx) begin
              st     <= RX_STOP;
              second <= 1'b0;
              ferr   <= 1'b0;
            end else begin
              bidx <= bidx + 4'd1;
            end
          end
        end
        RX_STOP: begin
          if (at_mid) begin
            if (fmt.two_stop && !second) begin
              second <= 1'b1;
              ferr   <= !vote;
            end else begin
              st <= RX_IDLE;
              if (accept) begin
                if (free) begin
                  rx_data  <= {n9 & !fmt.par_en, dbyte};
                  rx_full  <= 1'b1;
                  irq_full <= 1'b1;
                end
                err_code <= {!free, perr, fe};
                irq_err  <= !free | perr | fe;
              end
            end
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  p_full_flag_r7: assert property (@(posedge clk) disable iff (rst)
    irq_full |-> rx_full) else $error("ready pulse without full flag");
  p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
    rd |=> (!rx_full || irq_full)) else $error("read did not clear full flag");
  p_overrun_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_err && err_code[2]) |-> ($stable(rx_data) && rx_full && !irq_full))
    else $error("overrun replaced unread word");
  p_filter_r12: assert property (@(posedge clk) disable iff (rst)
    (irq_full && $past(mp_en) && !$past(fmt.par_en)) |-> rx_data[8])
    else $error("filtered frame delivered");
  p_err_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> (err_code != 3'b000)) else $error("error pulse with clean code");
endmodule

// File: rtl/uart_mp_xcvr.sv
module uart_mp_xcvr
  import uart_mp_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       cfg_nine,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic       cfg_mp,
  input  logic       cfg_loop,
  input  logic       tx_wr,
  input  logic [8:0] tx_data,
  output logic       tx_ready,
  input  logic       rx_rd,
  output logic [8:0] rx_data,
  output logic       rx_full,
  output logic [2:0] err_code,
  input  logic       rxd,
  output logic       txd,
  output logic       irq_tx_empty,
  output logic       irq_tx_last,
  output logic       irq_rx_full,
  output logic       irq_err
);
  fmt_t fmt;
  logic txd_int, rx_src;

  assign fmt    = '{nine: cfg_nine, par_en: cfg_par_en,
                    par_odd: cfg_par_odd, two_stop: cfg_two_stop};
  assign rx_src = cfg_loop ? txd_int : rxd;
  assign txd    = txd_int;

  uart_mp_tx #(.OVS(OVS)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .fmt      (fmt),
    .wr       (tx_wr),
    .wdata    (tx_data),
    .ready    (tx_ready),
    .txd      (txd_int),
    .irq_empty(irq_tx_empty),
    .irq_last (irq_tx_last)
  );

  uart_mp_rx #(.OVS(OVS), .SYNC(SYNC)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .fmt     (fmt),
    .mp_en   (cfg_mp),
    .rx_in   (rx_src),
    .rd      (rx_rd),
    .rx_data (rx_data),
    .rx_full (rx_full),
    .err_code(err_code),
    .irq_full(irq_rx_full),
    .irq_err (irq_err)
  );
endmodule

// File: tb/uart_mp_xcvr_test.sv
module uart_mp_xcvr_test;
  localparam int BT = 64;  // 16 ticks x 4 cycles

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [1:0] tdiv = 2'd0;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  logic tick;
  assign tick = (tdiv == 2'd3);

  logic cfg_nine = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0;
  logic cfg_mp = 0, cfg_loop = 0, tx_wr = 0, rx_rd = 0, rxd = 1;
  logic [8:0] tx_data = '0;
  logic tx_ready, rx_full, txd, irq_tx_empty, irq_tx_last, irq_rx_full, irq_err;
  logic [8:0] rx_data;
  logic [2:0] err_code;

  uart_mp_xcvr uut (
    .clk(clk), .rst(rst), .tick(tick),
    .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_mp(cfg_mp), .cfg_loop(cfg_loop),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full), .err_code(err_code),
    .rxd(rxd), .txd(txd), .irq_tx_empty(irq_tx_empty), .irq_tx_last(irq_tx_last),
    .irq_rx_full(irq_rx_full), .irq_err(irq_err)
  );

  int n_run = 0, n_fail = 0;
  int c_full = 0, c_err = 0, c_last = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (irq_rx_full) c_full++;
      if (irq_err)     c_err++;
      if (irq_tx_last) c_last++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic build(input logic [8:0] d, input logic n, input logic p, input logic o,
                       input logic t, output logic [11:0] b, output int nb);
    b = '1;
    b[0] = 1'b0;
    b[8:1] = d[7:0];
    if (n | p) begin
      b[9] = p ? ((^d[7:0]) ^ o) : d[8];
      nb = 11;
    end else begin
      nb = 10;
    end
    if (t) nb++;
  endtask

  task automatic set_fmt(input logic n, input logic p, input logic o, input logic t);
    @(negedge clk);
    cfg_nine = n; cfg_par_en = p; cfg_par_odd = o; cfg_two_stop = t;
  endtask

  task automatic wr_tx(input logic [8:0] d);
    @(negedge clk);
    tx_wr = 1'b1; tx_data = d;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic mon_tx(input int nb, output logic [11:0] bits, output int lc, output logic emp);
    int w;
    w = 0; bits = '1; lc = 0;
    while (txd !== 1'b0 && w < 3000) begin
      @(negedge clk);
      w++;
    end
    emp = irq_tx_empty;
    for (int c = 1; c <= nb * BT + 8; c++) begin
      @(negedge clk);
      if ((c % BT) == BT / 2 && (c / BT) < nb) bits[c / BT] = txd;
      if (irq_tx_last && lc == 0) lc = c;
    end
  endtask

  task automatic send_rx(input logic [11:0] bits, input int nb);
    for (int i = 0; i < nb; i++) begin
      rxd = bits[i];
      repeat (BT) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (BT) @(negedge clk);
  endtask

  task automatic wait_full();
    int w;
    w = 0;
    while (!rx_full && w < 4 * BT * 12) begin
      @(negedge clk);
      w++;
    end
  endtask

  task automatic rd_rx();
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  function automatic logic [8:0] pick(input int k);
    case (k)
      0: return 9'h1A5;
      1: return 9'h05A;
      2: return 9'h1FF;
      default: return 9'h100;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [11:0] b, got;
    logic [8:0] d;
    int nb, lc, f0, e0, l0;
    logic emp;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 txd", {31'd0, txd}, 1);
    chk("R1 tx_ready", {31'd0, tx_ready}, 1);
    chk("R1 rx_full", {31'd0, rx_full}, 0);
    chk("R1 err_code", {29'd0, err_code}, 0);
    chk("R1 irqs", {28'd0, irq_tx_empty, irq_tx_last, irq_rx_full, irq_err}, 0);

    // loop-back sweep over every frame format; rxd pin held low (R13)
    @(negedge clk); cfg_loop = 1'b1;
    @(negedge clk); rxd = 1'b0;
    for (int cf = 0; cf < 16; cf++) begin
      set_fmt(cf[0], cf[1], cf[2], cf[3]);
      for (int k = 0; k < 4; k++) begin
        d = pick(k);
        build(d, cf[0], cf[1], cf[2], cf[3], b, nb);
        fork
          mon_tx(nb, got, lc, emp);
          wr_tx(d);
        join
        chk("R2 R3 R4 line bits", {20'd0, got}, {20'd0, b});
        chk("R5 frame length", {31'd0, (lc >= nb * BT - 4 && lc <= nb * BT + 1)}, 1);
        chk("R6 empty pulse at start", {31'd0, emp}, 1);
        wait_full();
        chk("R7 R13 rx word", {23'd0, rx_data},
            {23'd0, (cf[0] & !cf[1] & d[8]), d[7:0]});
        chk("R4 clean code", {29'd0, err_code}, 0);
        rd_rx();
        chk("R7 read clears", {31'd0, rx_full}, 0);
      end
    end
    @(negedge clk); rxd = 1'b1;
    @(negedge clk); cfg_loop = 1'b0;
    repeat (BT) @(negedge clk);

    // external receive, 8 data + even parity
    set_fmt(0, 1, 0, 0);
    build(9'h0B4, 0, 1, 0, 0, b, nb);
    send_rx(b, nb);
    chk("R7 ext full", {31'd0, rx_full}, 1);
    chk("R7 ext word", {23'd0, rx_data}, 32'h0B4);
    chk("R4 ext clean", {29'd0, err_code}, 0);
    rd_rx();

    e0 = c_err;
    build(9'h0B5, 0, 1, 0, 0, b, nb);
    b[9] = ~b[9];
    send_rx(b, nb);
    chk("R4 parity error", {29'd0, err_code}, 3'b010);
    chk("R10 error pulse", e0 + 1, c_err);
    chk("R8 word delivered on error", {23'd0, rx_data}, 32'h0B5);
    rd_rx();

    set_fmt(0, 1, 1, 0);
    build(9'h0B5, 0, 1, 1, 0, b, nb);
    send_rx(b, nb);
    chk("R4 odd parity clean", {29'd0, err_code}, 0);
    chk("R4 odd word", {23'd0, rx_data}, 32'h0B5);
    rd_rx();

    set_fmt(0, 1, 0, 0);
    build(9'h03C, 0, 1, 0, 0, b, nb);
    b[10] = 1'b0;
    send_rx(b, nb);
    chk("R8 framing error", {29'd0, err_code}, 3'b001);
    chk("R8 word kept", {23'd0, rx_data}, 32'h03C);
    rd_rx();

    set_fmt(0, 1, 0, 1);
    build(9'h0C3, 0, 1, 0, 1, b, nb);
    b[11] = 1'b0;
    send_rx(b, nb);
    chk("R8 second stop low", {29'd0, err_code}, 3'b001);
    rd_rx();

    // start glitch
    set_fmt(0, 1, 0, 0);
    f0 = c_full;
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (4 * BT) @(negedge clk);
    chk("R11 glitch no frame", c_full, f0);
    chk("R11 glitch not full", {31'd0, rx_full}, 0);
    build(9'h0E1, 0, 1, 0, 0, b, nb);
    send_rx(b, nb);
    chk("R11 frame after glitch", {23'd0, rx_data}, 32'h0E1);
    chk("R11 clean after glitch", {29'd0, err_code}, 0);
    rd_rx();

    // overrun
    f0 = c_full; e0 = c_err;
    build(9'h011, 0, 1, 0, 0, b, nb);
    send_rx(b, nb);
    build(9'h022, 0, 1, 0, 0, b, nb);
    send_rx(b, nb);
    chk("R9 overrun code", {29'd0, err_code}, 3'b100);
    chk("R9 old word kept", {23'd0, rx_data}, 32'h011);
    chk("R9 one ready pulse", c_full, f0 + 1);
    chk("R10 overrun pulse", c_err, e0 + 1);
    rd_rx();

    // address filter
    set_fmt(1, 0, 0, 0);
    @(negedge clk); cfg_mp = 1'b1;
    f0 = c_full;
    build(9'h033, 1, 0, 0, 0, b, nb);
    send_rx(b, nb);
    chk("R12 data frame dropped", c_full, f0);
    chk("R12 not full", {31'd0, rx_full}, 0);
    build(9'h1C4, 1, 0, 0, 0, b, nb);
    send_rx(b, nb);
    chk("R12 address frame", {23'd0, rx_data}, 32'h1C4);
    rd_rx();
    @(negedge clk); cfg_mp = 1'b0;
    build(9'h033, 1, 0, 0, 0, b, nb);
    send_rx(b, nb);
    chk("R12 filter off", {23'd0, rx_data}, 32'h033);
    chk("R12 filter off full", {31'd0, rx_full}, 1);
    rd_rx();

    // transmit double buffer
    set_fmt(0, 0, 0, 0);
    @(negedge clk); cfg_loop = 1'b1;
    l0 = c_last;
    wr_tx(9'h03C);
    repeat (3) @(negedge clk);
    wr_tx(9'h0C3);
    chk("R6 holding busy", {31'd0, tx_ready}, 0);
    tx_wr = 1'b1; tx_data = 9'h055;
    @(negedge clk);
    tx_wr = 1'b0;
    wait_full();
    chk("R6 first word", {23'd0, rx_data}, 32'h03C);
    rd_rx();
    wait_full();
    chk("R6 second word", {23'd0, rx_data}, 32'h0C3);
    rd_rx();
    repeat (12 * BT) @(negedge clk);
    chk("R6 third write ignored", {31'd0, rx_full}, 0);
    chk("R5 two last pulses", c_last, l0 + 2);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule